// File: doc/BRIEF.md
# ACPI Power Management Event Block

This block holds the fixed power management event registers that system software reaches through a 64-byte I/O window. Three 16-bit registers carry event status, event enable and power management control. A free-running timer is read as a 32-bit word. The block combines status and enable into a level-sensitive system control interrupt (SCI). It turns sleep requests written to the control register into one-cycle request pulses for power-off, reset and suspend-to-RAM. It also receives command bytes from the legacy advanced power management port, which switch SCI on and off and can raise a system management interrupt.

The timer advances on a clock-enable strobe, `tmr_tick`. This strobe is normally generated at 3.579545 MHz outside the block. The timer is `TMR_W` bits wide and defaults to 24. Its status bit sets each time the count reaches the next half-range boundary. After software acknowledges the bit, the block arms the following boundary. A power-button input records an event only when its enable bit is set.

Top module: `acpi_pm_evt`

## Requirements
- R1: Only the low 6 bits of `acc_addr` select a register, so addresses that differ above bit 5 reach the same register.
- R2: A 16-bit access (`acc_wide`=0) reaches status at offset 0x00, enable at 0x02 and control at 0x04. A 32-bit access (`acc_wide`=1) reads the timer at offset 0x08. Every other read returns 0. Writes at any other offset and all 32-bit writes change nothing.
- R3: A 32-bit read at 0x08 returns the low `TMR_W` bits of a count, zero-extended. The count rises by one on each clock with `tmr_tick` high and wraps modulo 2^`TMR_W`.
- R4: After reset the overflow point is 2^(`TMR_W`-1). Status bit 0 (timer) reads 1 one clock after the count first equals the overflow point.
- R5: A write of 1 to status bit 0 while that bit is set clears it. The same write moves the overflow point to the current count plus 2^(`TMR_W`-1), rounded down to a multiple of 2^(`TMR_W`-1).
- R6: The status register is write-one-to-clear. Bits written 1 clear and bits written 0 keep their value. A hardware set in the same cycle wins over a clear.
- R7: A write to the enable register replaces all 16 bits.
- R8: `sci` is high exactly when status AND enable has a 1 in bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). Bit 15 (wake) never drives `sci`.
- R9: A control write stores all bits except bit 13 (sleep enable), which always reads back 0.
- R10: A control write with bit 13 set acts on the sleep type in bits 12:10. Type 0 gives a one-clock `shutdown_req` pulse. Type 1 sets status bits 15 and 8 and gives one-clock `reset_req` and `s3_req` pulses. Types 2 to 7 do nothing. Pulses appear in the clock after the write.
- R11: APM command 0xF1 sets control bit 0 (SCI enable) and 0xF0 clears it. Other bytes leave it unchanged.
- R12: Any APM command received while `smi_cfg_en` is high gives a one-clock `smi_req` pulse in the next clock. None is given while `smi_cfg_en` is low.
- R13: A `pwrbtn_evt` pulse sets status bit 8 only while enable bit 8 is set.
- R14: Reset clears status, enable, control and the count, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | Timer advance strobe |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| acc_addr | input | ADDR_W | I/O address; low 6 bits decoded |
| acc_wdata | input | 32 | Write data; 16-bit writes use bits 15:0 |
| acc_rdata | output | 32 | Read data, combinational, valid while reading |
| apm_valid | input | 1 | APM command byte strobe |
| apm_cmd | input | 8 | APM command byte |
| smi_cfg_en | input | 1 | SMI generation enabled by configuration |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| sci | output | 1 | System control interrupt level |
| smi_req | output | 1 | SMI request pulse |
| shutdown_req | output | 1 | Power-off request pulse |
| reset_req | output | 1 | System reset request pulse |
| s3_req | output | 1 | Suspend-to-RAM request pulse |

## Verification
The bound checker watches every cycle. It checks that the count steps on each tick, that a fallen timer status always leaves an overflow point ahead of the count, and that each request pulse has a matching sleep write or APM command the cycle before. It also checks that a suspend pulse comes with wake and power-button status, that APM 0xF1/0xF0 set and clear SCI enable, and that an enabled power button sets its status. Only the bench scenarios show the address aliasing, the zero reads of unmapped offsets, write-one-to-clear masking, the exact overflow cycle and the re-armed boundary. The same holds for SCI gating by each source and the silence of unused sleep types. The bench uses a 12-bit timer so that boundaries fall within a few thousand ticks.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;

   // status / enable bit positions
   localparam int unsigned EVT_TMR     = 0;
   localparam int unsigned EVT_GBL     = 5;
   localparam int unsigned EVT_PWRBTN  = 8;
   localparam int unsigned EVT_RTC     = 10;
   localparam int unsigned EVT_WAKE    = 15;

   // control bit positions
   localparam int unsigned CTL_SCI_EN  = 0;
   localparam int unsigned CTL_SLP_EN  = 13;
   localparam int unsigned CTL_TYP_LSB = 10;

   localparam logic [15:0] SCI_SRC_MASK = (16'h1 << EVT_TMR) | (16'h1 << EVT_GBL)
                                        | (16'h1 << EVT_PWRBTN) | (16'h1 << EVT_RTC);
   localparam logic [15:0] SLP_EN_MASK  = 16'h1 << CTL_SLP_EN;

   // window offsets
   localparam int unsigned WIN_BITS = 6;
   localparam logic [WIN_BITS-1:0] OFF_STS  = 6'h00;
   localparam logic [WIN_BITS-1:0] OFF_EN   = 6'h02;
   localparam logic [WIN_BITS-1:0] OFF_CTL  = 6'h04;
   localparam logic [WIN_BITS-1:0] OFF_TMR  = 6'h08;

   // APM commands
   localparam logic [7:0] APM_SCI_ON  = 8'hF1;
   localparam logic [7:0] APM_SCI_OFF = 8'hF0;

   // sleep types acted on
   typedef enum logic [2:0] {
      SLP_TYP_OFF = 3'd0,
      SLP_TYP_S3  = 3'd1
   } slp_typ_e;

   typedef struct packed {
      logic sts;
      logic en;
      logic ctl;
   } pm_wr_t;

endpackage

// File: rtl/acpi_pm_timer.sv
module acpi_pm_timer #(
   parameter int unsigned TMR_W = 24,
   parameter int unsigned EXT_W = 16,
   localparam int unsigned TIME_W = TMR_W + EXT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rearm_i,
   output logic [TMR_W-1:0]  cnt_o,
   output logic              hit_o,
   output logic [TIME_W-1:0] time_o,
   output logic [TIME_W-1:0] ovf_o
);
   localparam logic [TIME_W-1:0] ONE   = {{(TIME_W-1){1'b0}}, 1'b1};
   localparam logic [TIME_W-1:0] HALF  = ONE << (TMR_W - 1);
   localparam logic [TIME_W-1:0] ALIGN = ~(HALF - ONE);

   logic [TIME_W-1:0] time_q;
   logic [TIME_W-1:0] ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0;
         ovf_q  <= HALF;
      end else begin
         if (tick_i)
            time_q <= time_q + ONE;
         if (rearm_i)
            ovf_q <= (time_q + HALF) & ALIGN;
      end
   end

   assign hit_o  = (time_q >= ovf_q);
   assign cnt_o  = time_q[TMR_W-1:0];
   assign time_o = time_q;
   assign ovf_o  = ovf_q;
endmodule

// File: rtl/acpi_pm_status.sv
module acpi_pm_status
   import acpi_pm_pkg::*;
#(
   parameter bit SCI_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_sts_i,
   input  logic        wr_en_i,
   input  logic [15:0] wdata_i,
   input  logic        tmr_hit_i,
   input  logic        pwrbtn_i,
   input  logic        wake_set_i,
   output logic [15:0] sts_o,
   output logic [15:0] en_o,
   output logic        rearm_o,
   output logic        sci_o
);
   logic [15:0] sts_q, en_q;
   logic [15:0] sts_now, clr_mask, set_mask, sts_d, en_d;

   always_comb begin
      sts_now  = sts_q;
      if (tmr_hit_i)
         sts_now[EVT_TMR] = 1'b1;
      clr_mask = wr_sts_i ? wdata_i : 16'h0000;
      set_mask = 16'h0000;
      if (pwrbtn_i && en_q[EVT_PWRBTN])
         set_mask[EVT_PWRBTN] = 1'b1;
      if (wake_set_i) begin
         set_mask[EVT_PWRBTN] = 1'b1;
         set_mask[EVT_WAKE]   = 1'b1;
      end
      sts_d   = (sts_now & ~clr_mask) | set_mask;
      en_d    = wr_en_i ? wdata_i : en_q;
      rearm_o = wr_sts_i && wdata_i[EVT_TMR] && sts_now[EVT_TMR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= sts_d;
         en_q  <= en_d;
      end
   end

   generate
      if (SCI_REG) begin : g_sci_ff
         logic sci_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sci_q <= 1'b0;
            else        sci_q <= |(sts_d & en_d & SCI_SRC_MASK);
         end
         assign sci_o = sci_q;
      end else begin : g_sci_comb
         assign sci_o = |(sts_q & en_q & SCI_SRC_MASK);
      end
   endgenerate

   assign sts_o = sts_q;
   assign en_o  = en_q;
endmodule

// File: rtl/acpi_pm_ctl.sv
module acpi_pm_ctl
   import acpi_pm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctl_i,
   input  logic [15:0] wdata_i,
   input  logic        apm_valid_i,
   input  logic [7:0]  apm_cmd_i,
   input  logic        smi_cfg_i,
   output logic [15:0] ctl_o,
   output logic        wake_set_o,
   output logic        shutdown_o,
   output logic        reset_o,
   output logic        s3_o,
   output logic        smi_o
);
   logic [15:0] ctl_q;
   logic        slp_req;
   slp_typ_e    typ;
   logic        shutdown_q, reset_q, s3_q, smi_q;

   assign slp_req    = wr_ctl_i && wdata_i[CTL_SLP_EN];
   assign typ        = slp_typ_e'(wdata_i[CTL_TYP_LSB +: 3]);
   assign wake_set_o = slp_req && (typ == SLP_TYP_S3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         shutdown_q <= 1'b0;
         reset_q    <= 1'b0;
         s3_q       <= 1'b0;
         smi_q      <= 1'b0;
      end else begin
         if (wr_ctl_i)
            ctl_q <= wdata_i & ~SLP_EN_MASK;
         if (apm_valid_i) begin
            if (apm_cmd_i == APM_SCI_ON)
               ctl_q[CTL_SCI_EN] <= 1'b1;
            else if (apm_cmd_i == APM_SCI_OFF)
               ctl_q[CTL_SCI_EN] <= 1'b0;
         end
         shutdown_q <= slp_req && (typ == SLP_TYP_OFF);
         reset_q    <= wake_set_o;
         s3_q       <= wake_set_o;
         smi_q      <= apm_valid_i && smi_cfg_i;
      end
   end

   assign ctl_o      = ctl_q;
   assign shutdown_o = shutdown_q;
   assign reset_o    = reset_q;
   assign s3_o       = s3_q;
   assign smi_o      = smi_q;
endmodule

// File: rtl/acpi_pm_evt.sv
module acpi_pm_evt
   import acpi_pm_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned TMR_W   = 24,
   parameter int unsigned EXT_W   = 16,
   parameter bit          SCI_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_tick,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_wide,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   input  logic              apm_valid,
   input  logic [7:0]        apm_cmd,
   input  logic              smi_cfg_en,
   input  logic              pwrbtn_evt,
   output logic              sci,
   output logic              smi_req,
   output logic              shutdown_req,
   output logic              reset_req,
   output logic              s3_req
);
   localparam int unsigned TIME_W = TMR_W + EXT_W;

   generate
      if (ADDR_W < WIN_BITS) begin : g_bad_addr
         $error("acpi_pm_evt: ADDR_W must cover the 6-bit window");
      end
      if (TMR_W < 2 || TMR_W > 32) begin : g_bad_tmr
         $error("acpi_pm_evt: TMR_W must lie in 2..32");
      end
   endgenerate

   logic [WIN_BITS-1:0] off;
   pm_wr_t              wr;
   logic [15:0]         wdata16;
   logic [15:0]         sts_w, en_w, ctl_w;
   logic [TMR_W-1:0]    cnt_w;
   logic [TIME_W-1:0]   time_w, ovf_w;
   logic                hit_w, rearm_w, wake_set_w;

   assign off     = acc_addr[WIN_BITS-1:0];
   assign wdata16 = acc_wdata[15:0];

   always_comb begin
      wr = '0;
      if (acc_valid && acc_write && !acc_wide) begin
         wr.sts = (off == OFF_STS);
         wr.en  = (off == OFF_EN);
         wr.ctl = (off == OFF_CTL);
      end
   end

   acpi_pm_timer #(.TMR_W(TMR_W), .EXT_W(EXT_W)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tmr_tick),
      .rearm_i (rearm_w),
      .cnt_o   (cnt_w),
      .hit_o   (hit_w),
      .time_o  (time_w),
      .ovf_o   (ovf_w)
   );

   acpi_pm_status #(.SCI_REG(SCI_REG)) sts_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sts_i   (wr.sts),
      .wr_en_i    (wr.en),
      .wdata_i    (wdata16),
      .tmr_hit_i  (hit_w),
      .pwrbtn_i   (pwrbtn_evt),
      .wake_set_i (wake_set_w),
      .sts_o      (sts_w),
      .en_o       (en_w),
      .rearm_o    (rearm_w),
      .sci_o      (sci)
   );

   acpi_pm_ctl ctl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctl_i    (wr.ctl),
      .wdata_i     (wdata16),
      .apm_valid_i (apm_valid),
      .apm_cmd_i   (apm_cmd),
      .smi_cfg_i   (smi_cfg_en),
      .ctl_o       (ctl_w),
      .wake_set_o  (wake_set_w),
      .shutdown_o  (shutdown_req),
      .reset_o     (reset_req),
      .s3_o        (s3_req),
      .smi_o       (smi_req)
   );

   always_comb begin
      acc_rdata = 32'h0;
      if (acc_valid && !acc_write) begin
         if (acc_wide) begin
            if (off == OFF_TMR)
               acc_rdata = 32'(cnt_w);
         end else begin
            case (off)
               OFF_STS: acc_rdata = {16'h0, sts_w};
               OFF_EN:  acc_rdata = {16'h0, en_w};
               OFF_CTL: acc_rdata = {16'h0, ctl_w};
               default: acc_rdata = 32'h0;
            endcase
         end
      end
   end
endmodule

// File: rtl/acpi_pm_evt_chk.sv
module acpi_pm_evt_chk
   import acpi_pm_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned TIME_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tmr_tick,
   input logic              acc_valid,
   input logic              acc_write,
   input logic              acc_wide,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [31:0]       acc_wdata,
   input logic              apm_valid,
   input logic [7:0]        apm_cmd,
   input logic              smi_cfg_en,
   input logic              pwrbtn_evt,
   input logic [15:0]       sts,
   input logic [15:0]       en,
   input logic [15:0]       ctl,
   input logic [TIME_W-1:0] time_v,
   input logic [TIME_W-1:0] ovf_v,
   input logic              smi_req,
   input logic              shutdown_req,
   input logic              reset_req,
   input logic              s3_req
);
   logic ctl_wr, slp_off_wr, slp_s3_wr;
   assign ctl_wr     = acc_valid && acc_write && !acc_wide && (acc_addr[5:0] == OFF_CTL)
                       && acc_wdata[CTL_SLP_EN];
   assign slp_off_wr = ctl_wr && (acc_wdata[12:10] == 3'd0);
   assign slp_s3_wr  = ctl_wr && (acc_wdata[12:10] == 3'd1);

   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_tick |=> time_v == $past(time_v) + TIME_W'(1)); // R3
   AST_TMR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[EVT_TMR]) |-> ovf_v > $past(time_v)); // R5
   AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(slp_off_wr)); // R10
   AST_S3_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      s3_req |-> $past(slp_s3_wr) && reset_req); // R10
   AST_S3_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      s3_req |-> sts[EVT_WAKE] && sts[EVT_PWRBTN]); // R10
   AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req |-> $past(apm_valid && smi_cfg_en)); // R12
   AST_APM_ON: assert property (@(posedge clk) disable iff (!rst_n)
      apm_valid && apm_cmd == APM_SCI_ON |=> ctl[CTL_SCI_EN]); // R11
   AST_APM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      apm_valid && apm_cmd == APM_SCI_OFF |=> !ctl[CTL_SCI_EN]); // R11
   AST_PWRBTN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pwrbtn_evt && en[EVT_PWRBTN] |=> sts[EVT_PWRBTN]); // R13
endmodule

bind acpi_pm_evt acpi_pm_evt_chk #(.ADDR_W(ADDR_W), .TIME_W(TMR_W + EXT_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .tmr_tick     (tmr_tick),
   .acc_valid    (acc_valid),
   .acc_write    (acc_write),
   .acc_wide     (acc_wide),
   .acc_addr     (acc_addr),
   .acc_wdata    (acc_wdata),
   .apm_valid    (apm_valid),
   .apm_cmd      (apm_cmd),
   .smi_cfg_en   (smi_cfg_en),
   .pwrbtn_evt   (pwrbtn_evt),
   .sts          (sts_w),
   .en           (en_w),
   .ctl          (ctl_w),
   .time_v       (time_w),
   .ovf_v        (ovf_w),
   .smi_req      (smi_req),
   .shutdown_req (shutdown_req),
   .reset_req    (reset_req),
   .s3_req       (s3_req)
);

// File: tb/acpi_pm_evt_tb.sv
module acpi_pm_evt_tb_top;
   localparam int unsigned TMR_W = 12;
   localparam int unsigned HALF  = 1 << (TMR_W - 1);
   localparam int unsigned CMASK = (1 << TMR_W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_tick = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
   logic [15:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        apm_valid = 1'b0;
   logic [7:0]  apm_cmd = '0;
   logic        smi_cfg_en = 1'b0;
   logic        pwrbtn_evt = 1'b0;
   logic        sci, smi_req, shutdown_req, reset_req, s3_req;

   int checks = 0, errors = 0, cyc = 0;
   int unsigned tcount = 0;
   logic [4:0] pulses;   // {smi, shutdown, reset, s3, sci}

   always #2 clk = ~clk;

   acpi_pm_evt #(.TMR_W(TMR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_wide(acc_wide),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .apm_valid(apm_valid), .apm_cmd(apm_cmd), .smi_cfg_en(smi_cfg_en),
      .pwrbtn_evt(pwrbtn_evt), .sci(sci), .smi_req(smi_req),
      .shutdown_req(shutdown_req), .reset_req(reset_req), .s3_req(s3_req));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic capture();
      pulses = {smi_req, shutdown_req, reset_req, s3_req, sci};
   endtask

   task automatic wr(logic [15:0] addr, logic wide, logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_wide = wide;
      acc_addr = addr; acc_wdata = d;
      @(negedge clk);
      capture();
      acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0;
   endtask

   task automatic rd(logic [15:0] addr, logic wide, logic [31:0] exp, string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_wide = wide; acc_addr = addr;
      #1;
      check(tag, acc_rdata, exp);
      acc_valid = 1'b0; acc_wide = 1'b0;
   endtask

   task automatic apm(logic [7:0] c);
      @(negedge clk);
      apm_valid = 1'b1; apm_cmd = c;
      @(negedge clk);
      capture();
      apm_valid = 1'b0;
   endtask

   task automatic pwrbtn();
      @(negedge clk);
      pwrbtn_evt = 1'b1;
      @(negedge clk);
      pwrbtn_evt = 1'b0;
   endtask

   task automatic ticks(int n);
      @(negedge clk);
      tmr_tick = 1'b1;
      repeat (n) @(negedge clk);
      tmr_tick = 1'b0;
      tcount += n;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL R14 watchdog act=%0d exp<150000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R14 reset state
      check("R14 sci", {31'h0, sci}, 32'h0);
      check("R14 pulses", {27'h0, smi_req, shutdown_req, reset_req, s3_req, 1'b0}, 32'h0);
      rst_n = 1'b1;
      rd(16'h0000, 1'b0, 32'h0, "R14 status");
      rd(16'h0002, 1'b0, 32'h0, "R14 enable");
      rd(16'h0004, 1'b0, 32'h0, "R14 control");
      rd(16'h0008, 1'b1, 32'h0, "R14 count");

      // R7 enable replacement sweep
      for (int i = 0; i < 16; i++) begin
         wr(16'h0002, 1'b0, 32'h1 << i);
         rd(16'h0002, 1'b0, 32'h1 << i, "R7 enable walk");
      end
      // R1 aliasing above bit 5
      wr(16'hAE42, 1'b0, 32'h5A5A);
      rd(16'h0002, 1'b0, 32'h5A5A, "R1 alias write");
      rd(16'h13C2, 1'b0, 32'h5A5A, "R1 alias read");

      // R2 unmapped reads and ignored writes
      for (int o = 6; o < 64; o += 2)
         rd(16'(o), 1'b0, 32'h0, "R2 16-bit unmapped");
      for (int o = 0; o < 64; o += 4)
         if (o != 8) rd(16'(o), 1'b1, 32'h0, "R2 32-bit unmapped");
      wr(16'h0006, 1'b0, 32'hFFFF);
      wr(16'h0002, 1'b1, 32'h0000_0000);
      rd(16'h0002, 1'b0, 32'h5A5A, "R2 ignored writes enable");
      rd(16'h0000, 1'b0, 32'h0, "R2 ignored writes status");
      rd(16'h0004, 1'b0, 32'h0, "R2 ignored writes control");

      // R13 power button gating
      wr(16'h0002, 1'b0, 32'h0000);
      pwrbtn();
      rd(16'h0000, 1'b0, 32'h0, "R13 disabled button");
      wr(16'h0002, 1'b0, 32'h0100);
      pwrbtn();
      rd(16'h0000, 1'b0, 32'h0100, "R13 enabled button");
      idle();
      check("R8 sci from button", {31'h0, sci}, 32'h1);
      wr(16'h0002, 1'b0, 32'hFEFF);
      check("R8 sci masked", {31'h0, sci}, 32'h0);
      // R6 write-one-to-clear
      wr(16'h0000, 1'b0, 32'hFEFF);
      rd(16'h0000, 1'b0, 32'h0100, "R6 zero bits keep");
      wr(16'h0000, 1'b0, 32'h0100);
      rd(16'h0000, 1'b0, 32'h0, "R6 one bit clears");

      // R9 control storage, sleep enable reads 0
      wr(16'h0004, 1'b0, 32'h1C05);
      rd(16'h0004, 1'b0, 32'h1C05, "R9 store");
      for (int t = 2; t < 8; t++) begin
         wr(16'h0004, 1'b0, 32'h2000 | (t << 10));
         check("R10 idle type pulses", {27'h0, pulses[4:1], 1'b0}, 32'h0);
         rd(16'h0004, 1'b0, 32'(t << 10), "R9 sleep bit cleared");
      end
      rd(16'h0000, 1'b0, 32'h0, "R10 idle type status");
      wr(16'h0004, 1'b0, 32'h2000);
      check("R10 type0 shutdown", {27'h0, pulses}, 32'h08);
      idle();
      check("R10 shutdown one cycle", {31'h0, shutdown_req}, 32'h0);
      wr(16'h0002, 1'b0, 32'h8000);
      wr(16'h0004, 1'b0, 32'h2400);
      check("R10 type1 reset+s3", {27'h0, pulses[4:1], 1'b0}, 32'h06);
      rd(16'h0000, 1'b0, 32'h8100, "R10 wake status");
      check("R8 wake not a source", {31'h0, sci}, 32'h0);
      rd(16'h0004, 1'b0, 32'h0400, "R9 type1 stored");
      wr(16'h0000, 1'b0, 32'hFFFF);

      // R11 / R12 APM commands
      apm(8'hF1);
      check("R12 no smi when off", {31'h0, pulses[4]}, 32'h0);
      rd(16'h0004, 1'b0, 32'h0401, "R11 F1 sets");
      apm(8'h55);
      rd(16'h0004, 1'b0, 32'h0401, "R11 other byte");
      apm(8'hF0);
      rd(16'h0004, 1'b0, 32'h0400, "R11 F0 clears");
      smi_cfg_en = 1'b1;
      apm(8'h55);
      check("R12 smi pulse", {31'h0, pulses[4]}, 32'h1);
      idle();
      check("R12 smi one cycle", {31'h0, smi_req}, 32'h0);
      smi_cfg_en = 1'b0;

      // R3 / R4 / R5 timer
      wr(16'h0002, 1'b0, 32'h0001);
      rd(16'h0008, 1'b1, 32'h0, "R3 count start");
      rd(16'h0048, 1'b1, 32'h0, "R1 timer alias");
      ticks(100);
      rd(16'h0008, 1'b1, 32'(tcount & CMASK), "R3 count 100");
      ticks(HALF - 1 - 100);
      idle();
      rd(16'h0000, 1'b0, 32'h0, "R4 before boundary");
      check("R8 sci before boundary", {31'h0, sci}, 32'h0);
      ticks(1);
      rd(16'h0000, 1'b0, 32'h1, "R4 at boundary");
      check("R8 sci timer", {31'h0, sci}, 32'h1);
      ticks(100);
      wr(16'h0000, 1'b0, 32'hFFFE);
      rd(16'h0000, 1'b0, 32'h1, "R6 timer bit kept");
      wr(16'h0000, 1'b0, 32'h0001);
      rd(16'h0000, 1'b0, 32'h0, "R5 cleared");
      check("R8 sci after clear", {31'h0, sci}, 32'h0);
      ticks(2 * HALF - 1 - int'(tcount));
      idle();
      rd(16'h0008, 1'b1, 32'(tcount & CMASK), "R3 count top");
      rd(16'h0000, 1'b0, 32'h0, "R5 before next boundary");
      ticks(1);
      rd(16'h0008, 1'b1, 32'h0, "R3 wrap");
      rd(16'h0000, 1'b0, 32'h1, "R5 next boundary");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule